// File: doc/BRIEF.md
# Byte-Oriented I2C Master Controller

This block is a register-mapped I2C bus master. Software configures it through five byte-wide registers: an own-address register, a clock-divider select, a control register, a status register and a data register. Setting the master bit in control places a START on the bus, and clearing it places a STOP. A repeated START can be requested between bytes. Each byte moves on an access to the data register. In transmit direction a write sends a byte. In receive direction a read returns the previous byte and starts the next one, and the first byte is started by a dummy read.

SCL and SDA are open-drain. The block drives each line low through an enable output and reads the resolved level back on an input. Between bytes it holds SCL low until software touches the data register again. A parameter selects a variant register flavour. In that flavour the registers are packed at consecutive byte offsets, the enable bit in control has inverted sense, and status flags are cleared by writing one.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset the control and status registers read 0x00 (control reads 0x80 in the variant flavour) and neither SCL nor SDA is driven low.
- R2: Register index 0 is own address, 1 is divider, 2 is control, 3 is status and 4 is data. The byte offset is the index shifted left by 2, or by 0 in the variant flavour. Own address and divider read back what was written.
- R3: With the module enabled and the bus idle, writing control with bit 5 (master) set drives SDA low while SCL is released, and status bit 5 (bus busy) then reads 1.
- R4: In transmit direction (control bit 4 = 1), a data write shifts the byte out MSB first. After the ninth SCL pulse, status bit 1 (pending) and bit 7 (complete) read 1 and SCL stays driven low.
- R5: Status bit 0 reads 1 when the receiver left SDA high on the ninth clock (NACK), and 0 when it pulled SDA low.
- R6: In receive direction (control bit 4 = 0), a dummy data read starts the first byte. Each later data read returns the byte last received, MSB first, and starts the next byte while master is still set.
- R7: After a received byte the controller pulls SDA low on the ninth clock, unless control bit 3 (no-acknowledge) is set at that moment, in which case SDA is released.
- R8: Clearing the master bit produces a STOP (SDA rising while SCL is high). After that, bus busy reads 0 and both lines are released.
- R9: Writing control bit 2 while master and busy makes the next data write begin with a repeated START (SDA falling while SCL is high).
- R10: In the normal flavour, writing 0 to status bit 1 or bit 4 clears that flag, and writing 1 leaves it set.
- R11: In the variant flavour, control bit 7 = 0 means enabled, and writing 1 to status bit 1 clears the pending flag while writing 0 leaves it.
- R12: If SDA reads low during a transmitted data bit the controller left high, status bit 4 (arbitration lost) and bit 1 set, the master bit clears, both lines are released and bus busy reads 0.
- R13: Writing control with the module disabled aborts any transfer. Both lines are released at once, and bus busy, master and pending read 0.
- R14: Each SCL high phase lasts (div[3:0] + 2) << div[5:4] system clocks, where div is the divider register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Register byte offset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (side effect on data register) |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the addressed register |
| sclOe | output | 1 | Drive SCL low when 1 |
| sclIn | input | 1 | Resolved SCL level |
| sdaOe | output | 1 | Drive SDA low when 1 |
| sdaIn | input | 1 | Resolved SDA level |

## Verification
The hardest state to reach from the ports is arbitration loss. It needs a second device to pull SDA low at the moment the controller releases it for a one bit, with SCL high. The bench slave model is told to return data during a byte the controller transmits. Its all-zero byte collides with the controller's 0xFF on the first bit. The same model drives ACK/NACK and read data on SCL edges. It also logs START and STOP conditions and the width of each SCL high phase, so the repeated START and the divider timing are observed on the lines themselves.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int BYTE_W = 8;

  // control -> bit engine: strobes plus the live no-ack level
  typedef struct packed {
    logic              flush;
    logic              start;
    logic              stop;
    logic              go;
    logic              rstart;
    logic              tx;
    logic              nack;
    logic [BYTE_W-1:0] txByte;
  } dpCmd_t;

  // bit engine -> control
  typedef struct packed {
    logic              done;
    logic              arbLost;
    logic              ackIn;
    logic              hold;
    logic              busy;
    logic [BYTE_W-1:0] rxByte;
  } dpStat_t;
endpackage

// File: rtl/i2cm_bit_engine.sv
module i2cm_bit_engine
  import i2cm_pkg::*;
#(
  parameter int HALF_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [5:0] divSel,
  input  dpCmd_t     cmd,
  output dpStat_t    stat,
  output logic       sclLow,
  output logic       sdaLow,
  input  logic       sclIn,
  input  logic       sdaIn
);
  localparam int BIT_W = $clog2(BYTE_W + 1);
  localparam logic [BIT_W-1:0] ACK_SLOT = BIT_W'(BYTE_W);

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_HOLD, S_RS1, S_RS2, S_RS3,
    S_BLO, S_BHI, S_STOP1, S_STOP2
  } state_t;

  state_t             st;
  logic [HALF_W-1:0]  cnt, halfLen;
  logic [BIT_W-1:0]   bitIdx;
  logic [BYTE_W-1:0]  shReg;
  logic               txMode, timed, tick;
  logic               doneQ, arbQ, ackQ;

  always_comb begin
    halfLen = (HALF_W'(divSel[3:0]) + HALF_W'(2)) << divSel[5:4];
    timed   = (st != S_IDLE) && (st != S_HOLD);
    tick    = timed && (cnt == halfLen - HALF_W'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st <= S_IDLE; cnt <= '0; bitIdx <= '0; shReg <= '0; txMode <= 1'b0;
      sclLow <= 1'b0; sdaLow <= 1'b0; doneQ <= 1'b0; arbQ <= 1'b0; ackQ <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      arbQ  <= 1'b0;
      cnt   <= (tick || !timed) ? '0 : cnt + HALF_W'(1);
      if (cmd.flush) begin
        st <= S_IDLE; sclLow <= 1'b0; sdaLow <= 1'b0; cnt <= '0;
      end else begin
        case (st)
          S_IDLE:  if (cmd.start) begin sdaLow <= 1'b1; st <= S_START; end
          S_START: if (tick) begin sclLow <= 1'b1; st <= S_HOLD; end
          S_HOLD: begin
            if (cmd.go) begin
              txMode <= cmd.tx;
              shReg  <= cmd.tx ? cmd.txByte : '1;
              bitIdx <= '0;
              if (cmd.rstart) begin sdaLow <= 1'b0; st <= S_RS1; end
              else st <= S_BLO;
            end else if (cmd.stop) begin
              sdaLow <= 1'b1; st <= S_STOP1;
            end
          end
          S_RS1: if (tick) begin sclLow <= 1'b0; st <= S_RS2; end
          S_RS2: if (tick) begin sdaLow <= 1'b1; st <= S_RS3; end
          S_RS3: if (tick) begin sclLow <= 1'b1; st <= S_BLO; end
          S_BLO: begin
            // data changes one clock after SCL fell
            if (cnt == '0) begin
              if (bitIdx == ACK_SLOT) sdaLow <= txMode ? 1'b0 : !cmd.nack;
              else                    sdaLow <= txMode ? !shReg[BYTE_W-1] : 1'b0;
            end
            if (tick) begin sclLow <= 1'b0; st <= S_BHI; end
          end
          S_BHI: if (tick) begin
            if (txMode && (bitIdx != ACK_SLOT) && !sdaLow && !sdaIn) begin
              arbQ <= 1'b1; sclLow <= 1'b0; sdaLow <= 1'b0; st <= S_IDLE;
            end else if (bitIdx == ACK_SLOT) begin
              ackQ <= sdaIn; doneQ <= 1'b1; sclLow <= 1'b1; st <= S_HOLD;
            end else begin
              shReg  <= {shReg[BYTE_W-2:0], sdaIn};
              bitIdx <= bitIdx + BIT_W'(1);
              sclLow <= 1'b1;
              st     <= S_BLO;
            end
          end
          S_STOP1: if (tick) begin sclLow <= 1'b0; st <= S_STOP2; end
          S_STOP2: if (tick) begin sdaLow <= 1'b0; st <= S_IDLE; end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    stat.done    = doneQ;
    stat.arbLost = arbQ;
    stat.ackIn   = ackQ;
    stat.hold    = (st == S_HOLD);
    stat.busy    = (st != S_IDLE);
    stat.rxByte  = shReg;
  end

  // SCL level is not used for stretching in this engine
  logic sclUnused;
  assign sclUnused = sclIn;
endmodule

// File: rtl/i2cm_regs_ctrl.sv
module i2cm_regs_ctrl
  import i2cm_pkg::*;
#(
  parameter bit VARIANT = 1'b0,
  parameter int ADDR_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rdData,
  input  dpStat_t           stat,
  output dpCmd_t            cmd,
  output logic [5:0]        divSel,
  output logic              mstaQ
);
  localparam int SHIFT = VARIANT ? 0 : 2;
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << SHIFT) - 1);

  logic [ADDR_W-1:0] idxFull;
  logic aligned, selOwn, selDiv, selCtl, selSt, selDat;
  logic [BYTE_W-1:0] ownAddr, divReg, goByte;
  logic en, ien, mtx, txak, icf, ial, iif, rxak;
  logic goPend, goTx, stopPend, rstaPend;
  logic enIn, clrIif, clrIal;

  always_comb begin
    idxFull = addr >> SHIFT;
    aligned = (addr & LOW_MASK) == '0;
    selOwn  = aligned && (idxFull == ADDR_W'(0));
    selDiv  = aligned && (idxFull == ADDR_W'(1));
    selCtl  = aligned && (idxFull == ADDR_W'(2));
    selSt   = aligned && (idxFull == ADDR_W'(3));
    selDat  = aligned && (idxFull == ADDR_W'(4));
    enIn    = VARIANT ? !wrData[7] : wrData[7];
    clrIif  = VARIANT ?  wrData[1] : !wrData[1];
    clrIal  = VARIANT ?  wrData[4] : !wrData[4];
  end

  always_comb begin
    cmd.flush  = wrEn && selCtl && !enIn;
    cmd.start  = wrEn && selCtl && enIn && wrData[5] && !mstaQ && !stat.busy;
    cmd.go     = goPend && stat.hold;
    cmd.stop   = stopPend && stat.hold && !goPend;
    cmd.rstart = rstaPend;
    cmd.tx     = goTx;
    cmd.nack   = txak;
    cmd.txByte = goByte;
    divSel     = divReg[5:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ownAddr <= '0; divReg <= '0; goByte <= '0;
      en <= 1'b0; ien <= 1'b0; mstaQ <= 1'b0; mtx <= 1'b0; txak <= 1'b0;
      icf <= 1'b0; ial <= 1'b0; iif <= 1'b0; rxak <= 1'b0;
      goPend <= 1'b0; goTx <= 1'b0; stopPend <= 1'b0; rstaPend <= 1'b0;
    end else begin
      if (cmd.go)   begin goPend <= 1'b0; rstaPend <= 1'b0; end
      if (cmd.stop) stopPend <= 1'b0;
      if (wrEn) begin
        if (selOwn) ownAddr <= wrData;
        if (selDiv) divReg  <= wrData;
        if (selCtl) begin
          en <= enIn; ien <= wrData[6]; mtx <= wrData[4]; txak <= wrData[3];
          if (!enIn) begin
            mstaQ <= 1'b0; iif <= 1'b0;
            goPend <= 1'b0; stopPend <= 1'b0; rstaPend <= 1'b0;
          end else begin
            if (cmd.start) begin
              mstaQ <= 1'b1; stopPend <= 1'b0;
            end else if (!wrData[5] && mstaQ) begin
              mstaQ <= 1'b0; stopPend <= stat.busy;
            end
            if (wrData[2] && wrData[5] && mstaQ && stat.busy) rstaPend <= 1'b1;
          end
        end
        if (selSt) begin
          if (clrIif) iif <= 1'b0;
          if (clrIal) ial <= 1'b0;
        end
        if (selDat && en && mstaQ && mtx) begin
          goPend <= 1'b1; goTx <= 1'b1; goByte <= wrData; icf <= 1'b0;
        end
      end
      if (rdEn && selDat && en && mstaQ && !mtx) begin
        goPend <= 1'b1; goTx <= 1'b0; icf <= 1'b0;
      end
      if (stat.done) begin iif <= 1'b1; icf <= 1'b1; rxak <= stat.ackIn; end
      if (stat.arbLost) begin
        ial <= 1'b1; iif <= 1'b1; mstaQ <= 1'b0;
        goPend <= 1'b0; stopPend <= 1'b0; rstaPend <= 1'b0;
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (selOwn) rdData = ownAddr;
    if (selDiv) rdData = divReg;
    if (selCtl) rdData = {VARIANT ? !en : en, ien, mstaQ, mtx, txak, 3'b000};
    if (selSt)  rdData = {icf, 1'b0, stat.busy, ial, 2'b00, iif, rxak};
    if (selDat) rdData = stat.rxByte;
  end
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2cm_pkg::*;
#(
  parameter bit VARIANT = 1'b0,
  parameter int ADDR_W  = 5,
  parameter int HALF_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic              sclOe,
  input  logic              sclIn,
  output logic              sdaOe,
  input  logic              sdaIn
);
  dpCmd_t     dpCmd;
  dpStat_t    dpStat;
  logic [5:0] divSel;
  logic       mstaQ;
  logic       busBusy, byteDone, arbLost;

  i2cm_regs_ctrl #(.VARIANT(VARIANT), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .stat(dpStat), .cmd(dpCmd),
    .divSel(divSel), .mstaQ(mstaQ)
  );

  i2cm_bit_engine #(.HALF_W(HALF_W)) u_eng (
    .clk(clk), .rstN(rstN), .divSel(divSel), .cmd(dpCmd), .stat(dpStat),
    .sclLow(sclOe), .sdaLow(sdaOe), .sclIn(sclIn), .sdaIn(sdaIn)
  );

  assign busBusy  = dpStat.busy;
  assign byteDone = dpStat.done;
  assign arbLost  = dpStat.arbLost;
endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker #(
  parameter bit VARIANT = 1'b0,
  parameter int ADDR_W  = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wrData,
  input logic              sclOe,
  input logic              sdaOe,
  input logic              busBusy,
  input logic              byteDone,
  input logic              arbLost,
  input logic              mstaQ
);
  localparam logic [ADDR_W-1:0] CTL_OFF = ADDR_W'(2 << (VARIANT ? 0 : 2));
  logic disWr;
  assign disWr = wrEn && (addr == CTL_OFF) && (VARIANT ? wrData[7] : !wrData[7]);

  assert_disable_release_R13: assert property (@(posedge clk) disable iff (!rstN)
    disWr |=> (!sclOe && !sdaOe && !busBusy));

  assert_arb_release_R12: assert property (@(posedge clk) disable iff (!rstN)
    (arbLost && !disWr) |=> (!sclOe && !sdaOe && !mstaQ && !busBusy));

  assert_hold_scl_R4: assert property (@(posedge clk) disable iff (!rstN)
    (byteDone && !disWr) |=> sclOe);

  assert_start_shape_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busBusy) |-> (sdaOe && !sclOe));

  assert_idle_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busBusy) |-> (!sclOe && !sdaOe));
endmodule

bind i2c_byte_master i2cm_checker #(.VARIANT(VARIANT), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .sclOe(sclOe), .sdaOe(sdaOe), .busBusy(busBusy), .byteDone(byteDone),
  .arbLost(arbLost), .mstaQ(mstaQ)
);

// File: tb/test_i2c_byte_master.sv
`timescale 1ns/1ps
module test_i2c_byte_master;
  localparam logic [4:0] A_OWN = 5'd0, A_DIV = 5'd4, A_CTL = 5'd8, A_ST = 5'd12, A_DAT = 5'd16;
  // {ackEnable, byte}
  localparam logic [8:0] TX_VEC [5] = '{9'h1A5, 9'h13C, 9'h0FF, 9'h100, 9'h081};

  logic clk = 1'b0, rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic [4:0] addr = '0, vAddr = '0;
  logic wrEn = 0, rdEn = 0, vWrEn = 0, vRdEn = 0;
  logic [7:0] wrData = '0, vWrData = '0, rdData, vRdData;
  logic sclOe, sdaOe, vSclOe, vSdaOe;
  logic slvSdaLow = 1'b0;
  wire sclLine = !sclOe;
  wire sdaLine = !(sdaOe || slvSdaLow);

  i2c_byte_master i_i2c_byte_master (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn), .wrData(wrData),
    .rdData(rdData), .sclOe(sclOe), .sclIn(sclLine), .sdaOe(sdaOe), .sdaIn(sdaLine));

  i2c_byte_master #(.VARIANT(1'b1)) i_i2c_byte_master_var (
    .clk(clk), .rstN(rstN), .addr(vAddr), .wrEn(vWrEn), .rdEn(vRdEn), .wrData(vWrData),
    .rdData(vRdData), .sclOe(vSclOe), .sclIn(!vSclOe), .sdaOe(vSdaOe), .sdaIn(!vSdaOe));

  int nChk = 0, nBad = 0;
  // slave model state
  logic slvRead = 0, slvAck = 1, slvKill = 0;
  logic [7:0] slvTx = '0, rxShift = '0;
  logic mAckSeen = 0, sclPrev = 1, sdaPrev = 1;
  int bitCnt = 0, startCnt = 0, stopCnt = 0, highRun = 0, lastHigh = 0;

  always @(negedge clk) begin
    if (sclLine && sclPrev && sdaPrev && !sdaLine) begin startCnt++; bitCnt = 0; end
    else if (sclLine && sclPrev && !sdaPrev && sdaLine) begin stopCnt++; bitCnt = 0; end
    else if (sclLine && !sclPrev) begin
      if (bitCnt < 8) rxShift = {rxShift[6:0], sdaLine};
      else if (bitCnt == 8) mAckSeen = sdaLine;
      bitCnt++;
    end else if (!sclLine && sclPrev) begin
      lastHigh = highRun;
      if (bitCnt >= 9) bitCnt = 0;
    end
    if (sclLine) highRun = (sclPrev ? highRun : 0) + 1;
    if (!sclLine) begin
      if (bitCnt == 8) slvSdaLow = !slvRead && slvAck;
      else if (slvRead && bitCnt < 8) slvSdaLow = !slvTx[7 - bitCnt];
      else slvSdaLow = 1'b0;
    end
    if (slvKill) slvSdaLow = 1'b0;
    sclPrev = sclLine;
    sdaPrev = sdaLine;
  end

  task automatic check(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit v, input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    if (v) begin vAddr = a; vWrData = d; vWrEn = 1; end
    else begin addr = a; wrData = d; wrEn = 1; end
    @(negedge clk);
    wrEn = 0; vWrEn = 0;
  endtask

  task automatic rd(input bit v, input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    if (v) begin vAddr = a; vRdEn = 1; #1 d = vRdData; end
    else begin addr = a; rdEn = 1; #1 d = rdData; end
    @(negedge clk);
    rdEn = 0; vRdEn = 0;
  endtask

  task automatic waitBit(input bit v, input int b, input logic val, input string tag);
    logic [7:0] s;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (v) begin vAddr = v ? 5'd3 : A_ST; #1 s = vRdData; end
      else begin addr = A_ST; #1 s = rdData; end
      if (s[b] == val) return;
    end
    check(tag, 0, 1);
  endtask

  logic [7:0] rv;

  initial begin
    #(5ns * 150000);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rd(0, A_CTL, rv); check("R1 ctl", rv, 8'h00);
    rd(0, A_ST, rv);  check("R1 st", rv, 8'h00);
    check("R1 lines", {sclOe, sdaOe}, 0);
    rd(1, 5'd2, rv);  check("R1 variant ctl", rv, 8'h80);
    // R2 register map
    wr(0, A_OWN, 8'h5A); wr(0, A_DIV, 8'h00);
    rd(0, A_OWN, rv); check("R2 own", rv, 8'h5A);
    rd(0, A_DIV, rv); check("R2 div", rv, 8'h00);
    wr(1, 5'd0, 8'h33); wr(1, 5'd1, 8'h07);
    rd(1, 5'd0, rv); check("R2 variant own", rv, 8'h33);
    rd(1, 5'd1, rv); check("R2 variant div", rv, 8'h07);
    // R3 start
    wr(0, A_CTL, 8'h80);
    wr(0, A_CTL, 8'hB0);
    waitBit(0, 5, 1'b1, "R3 busy timeout");
    rd(0, A_ST, rv); check("R3 busy", rv[5], 1);
    check("R3 start seen", startCnt, 1);
    // R4/R5 table of transmitted bytes
    foreach (TX_VEC[k]) begin
      slvAck = TX_VEC[k][8];
      wr(0, A_ST, 8'h00);
      wr(0, A_DAT, TX_VEC[k][7:0]);
      waitBit(0, 1, 1'b1, "R4 done timeout");
      check("R4 byte on bus", rxShift, TX_VEC[k][7:0]);
      rd(0, A_ST, rv);
      check("R4 complete", rv[7], 1);
      check("R5 ack bit", rv[0], !TX_VEC[k][8]);
      check("R4 scl held", sclOe, 1);
    end
    check("R14 high phase div0", lastHigh, 2);
    // R9 repeated start
    slvAck = 1;
    wr(0, A_CTL, 8'hB4);
    wr(0, A_ST, 8'h00);
    wr(0, A_DAT, 8'hA1);
    waitBit(0, 1, 1'b1, "R9 done timeout");
    check("R9 repeated start", startCnt, 2);
    check("R9 byte", rxShift, 8'hA1);
    // R6/R7 receive
    slvRead = 1; slvTx = 8'hC3;
    wr(0, A_CTL, 8'hA0);
    wr(0, A_ST, 8'h00);
    rd(0, A_DAT, rv);
    waitBit(0, 1, 1'b1, "R6 first timeout");
    check("R7 ack driven", mAckSeen, 0);
    slvTx = 8'h5E;
    wr(0, A_CTL, 8'hA8);
    wr(0, A_ST, 8'h00);
    rd(0, A_DAT, rv);
    check("R6 first byte", rv, 8'hC3);
    waitBit(0, 1, 1'b1, "R6 second timeout");
    check("R7 nack sent", mAckSeen, 1);
    slvRead = 0;
    // R8 stop
    wr(0, A_CTL, 8'h88);
    waitBit(0, 5, 1'b0, "R8 idle timeout");
    rd(0, A_DAT, rv); check("R6 last byte", rv, 8'h5E);
    check("R8 stop seen", stopCnt, 1);
    check("R8 lines free", {sclOe, sdaOe}, 0);
    // R10 flag clear, normal flavour
    wr(0, A_CTL, 8'hB0);
    waitBit(0, 5, 1'b1, "R10 busy timeout");
    wr(0, A_ST, 8'h00);
    wr(0, A_DAT, 8'h3E);
    waitBit(0, 1, 1'b1, "R10 done timeout");
    wr(0, A_ST, 8'h02);
    rd(0, A_ST, rv); check("R10 write1 keeps", rv[1], 1);
    wr(0, A_ST, 8'h00);
    rd(0, A_ST, rv); check("R10 write0 clears", rv[1], 0);
    wr(0, A_CTL, 8'h90);
    waitBit(0, 5, 1'b0, "R10 stop timeout");
    // R14 slower divider
    wr(0, A_DIV, 8'h13);
    wr(0, A_CTL, 8'hB0);
    waitBit(0, 5, 1'b1, "R14 busy timeout");
    wr(0, A_ST, 8'h00);
    wr(0, A_DAT, 8'h42);
    waitBit(0, 1, 1'b1, "R14 done timeout");
    check("R14 high phase div13", lastHigh, 10);
    // R13 disable mid-byte
    wr(0, A_DAT, 8'h55);
    repeat (25) @(negedge clk);
    wr(0, A_CTL, 8'h00);
    check("R13 lines", {sclOe, sdaOe}, 0);
    rd(0, A_ST, rv); check("R13 status", rv & 8'h22, 0);
    rd(0, A_CTL, rv); check("R13 master", rv[5], 0);
    slvKill = 1; repeat (2) @(negedge clk); slvKill = 0;
    // R12 arbitration loss
    wr(0, A_DIV, 8'h00);
    wr(0, A_CTL, 8'h80);
    wr(0, A_CTL, 8'hB0);
    waitBit(0, 5, 1'b1, "R12 busy timeout");
    slvRead = 1; slvTx = 8'h00;
    wr(0, A_ST, 8'h00);
    wr(0, A_DAT, 8'hFF);
    waitBit(0, 1, 1'b1, "R12 flag timeout");
    rd(0, A_ST, rv);
    check("R12 lost flag", rv[4], 1);
    check("R12 not busy", rv[5], 0);
    rd(0, A_CTL, rv); check("R12 master cleared", rv[5], 0);
    check("R12 lines", {sclOe, sdaOe}, 0);
    slvKill = 1; slvRead = 0;
    wr(0, A_ST, 8'h00);
    rd(0, A_ST, rv); check("R10 lost cleared", rv[4], 0);
    // R11 variant flavour
    wr(1, 5'd1, 8'h00);
    wr(1, 5'd2, 8'h00);
    rd(1, 5'd2, rv); check("R11 enabled reads 0", rv, 8'h00);
    wr(1, 5'd2, 8'h30);
    waitBit(1, 5, 1'b1, "R11 busy timeout");
    wr(1, 5'd4, 8'h12);
    waitBit(1, 1, 1'b1, "R11 done timeout");
    rd(1, 5'd3, rv); check("R11 nack", rv[0], 1);
    wr(1, 5'd3, 8'h00);
    rd(1, 5'd3, rv); check("R11 write0 keeps", rv[1], 1);
    wr(1, 5'd3, 8'h02);
    rd(1, 5'd3, rv); check("R11 write1 clears", rv[1], 0);
    wr(1, 5'd2, 8'h10);
    waitBit(1, 5, 1'b0, "R11 stop timeout");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule